// File: doc/BRIEF.md
# Trimmed-Mean Sample Filter

This block reduces a burst of raw readings from a single sensor to one filtered value per round. A sequencer pulses a start strobe together with a 3-bit mode. The block latches the mode, reports how many readings it needs, and then accepts readings on a valid strobe. When the last reading of the round arrives, it emits one result pulse with the filtered value.

Small modes either pass one reading through or average two. The larger modes gather N readings (4, 6, 10 or 18), drop one largest and one smallest reading, and average the N-2 that remain. N-2 is always a power of two, so the division is a right shift. Each raw input word is cut down to the measurement field width before any arithmetic is done. The block keeps a running sum, maximum and minimum, so no reading is stored.

Top module: `trimmed_mean_filter`

## Requirements
- R1: While reset is asserted and after it is released, `req_count_o`, `res_valid_o` and `res_value_o` are all zero until the first round is started.
- R2: A `start_i` pulse latches `mode_i`. From the following cycle, `req_count_o` shows the round size: mode 0→1, 1→2, 2→4, 3→6, 4→10, 5→18.
- R3: Modes 6 and 7 behave exactly like mode 0: the request count is 1 and the single reading passes through.
- R4: In mode 0, the result equals the one masked reading.
- R5: In mode 1, the result is floor((a+b)/2) of the two masked readings.
- R6: In modes 2 to 5, the result is floor((sum − max − min)/(N−2)) over the N masked readings of the round, whatever order they arrive in.
- R7: When several readings tie for the largest or the smallest value, only one copy of each is removed.
- R8: Only the low `RAW_W` bits of `smp_raw_i` are used. Higher bits have no effect on the result.
- R9: `res_valid_o` is high for exactly one cycle. That cycle immediately follows the clock edge that accepted the round's last reading. `res_value_o` holds its value until the next result.
- R10: Readings presented while no round is open are ignored. They produce no result and have no effect on the next round.
- R11: A `start_i` pulse during an open round discards the partial round. A reading presented in the same cycle as `start_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens a new round and latches the mode |
| mode_i | input | 3 | Filter mode, sampled with `start_i` |
| smp_valid_i | input | 1 | A reading is present on `smp_raw_i` |
| smp_raw_i | input | IN_W | Raw reading word; only the low RAW_W bits are used |
| req_count_o | output | 5 | Number of readings the current mode needs |
| res_valid_o | output | 1 | One-cycle pulse when a result is ready |
| res_value_o | output | RAW_W | Filtered value of the latest round |

## Verification
A wrong running maximum or minimum shows up only at the end of a round, as a result that is too low or too high. The test readings therefore put the extremes at different positions and include ties, so that every trimmed mode exposes a bad extreme on its single result pulse. A wrong reading counter shows up as a result pulse that comes a cycle early or late, or never comes, relative to the request count; every round checks the exact cycle of the pulse. A stale accumulator left over from an idle period or an aborted round corrupts the very next result, so idle readings and restarts are each followed directly by a checked round.

// File: rtl/tmf_pkg.sv
// Package: shared constants, the per-mode configuration record and the mode decoder.
// Assumes the largest round holds fewer than 2**CNT_W readings.
package tmf_pkg;
    localparam int CNT_W = 5;
    localparam int SHF_W = 3;

    typedef struct packed {
        logic [CNT_W-1:0] n;     // readings per round
        logic             trim;  // drop one max and one min
        logic [SHF_W-1:0] shift; // log2 of the divisor
    } tmf_cfg_t;

    // Map a mode code onto round size, trimming and shift; unused codes fall back to mode 0.
    function automatic tmf_cfg_t tmf_decode(input logic [2:0] m);
        tmf_cfg_t c;
        case (m)
            3'd1:    c = '{n: 5'd2,  trim: 1'b0, shift: 3'd1};
            3'd2:    c = '{n: 5'd4,  trim: 1'b1, shift: 3'd1};
            3'd3:    c = '{n: 5'd6,  trim: 1'b1, shift: 3'd2};
            3'd4:    c = '{n: 5'd10, trim: 1'b1, shift: 3'd3};
            3'd5:    c = '{n: 5'd18, trim: 1'b1, shift: 3'd4};
            default: c = '{n: 5'd1,  trim: 1'b0, shift: 3'd0};
        endcase
        return c;
    endfunction
endpackage

// File: rtl/tmf_mode_reg.sv
// Mode register: decodes mode_i and holds the resulting round configuration.
// The configuration is loaded only by start_i; reset clears it to all zero.
module tmf_mode_reg
    import tmf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic [2:0] mode_i,
    output tmf_cfg_t cfg_o
);
    tmf_cfg_t cfg_q;

    // Load the decoded configuration on each start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (start_i) cfg_q <= tmf_decode(mode_i);
    end

    assign cfg_o = cfg_q;

    // R2
    legal_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cfg_q.n == 5'd1 || cfg_q.n == 5'd2 || cfg_q.n == 5'd4 ||
                     cfg_q.n == 5'd6 || cfg_q.n == 5'd10 || cfg_q.n == 5'd18));
endmodule

// File: rtl/tmf_accum.sv
// Accumulator: counts the readings of an open round and keeps a running sum, max and min.
// It exposes the values as they will be after the current reading, and flags the
// reading that closes the round. Assumes n_i is stable and nonzero while a round is open.
module tmf_accum
    import tmf_pkg::*;
#(
    parameter int RAW_W = 16,
    localparam int SUM_W = RAW_W + CNT_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] n_i,
    input  logic             smp_valid_i,
    input  logic [RAW_W-1:0] smp_i,
    output logic             last_o,
    output logic [SUM_W-1:0] sum_nxt_o,
    output logic [RAW_W-1:0] max_nxt_o,
    output logic [RAW_W-1:0] min_nxt_o
);
    logic             open_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum_q;
    logic [RAW_W-1:0] max_q, min_q;
    logic             take;

    // Accept a reading only inside an open round and never in a start cycle.
    assign take = smp_valid_i && open_q && !start_i;
    assign last_o = take && (cnt_q == n_i - 5'd1);

    // Combine the current reading with the running statistics.
    always_comb begin
        sum_nxt_o = sum_q + SUM_W'(smp_i);
        max_nxt_o = (smp_i > max_q) ? smp_i : max_q;
        min_nxt_o = (smp_i < min_q) ? smp_i : min_q;
    end

    // Open, advance and close rounds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
            sum_q  <= '0;
            max_q  <= '0;
            min_q  <= '1;
        end else if (start_i) begin
            open_q <= 1'b1;
            cnt_q  <= '0;
            sum_q  <= '0;
            max_q  <= '0;
            min_q  <= '1;
        end else if (take) begin
            cnt_q  <= cnt_q + 5'd1;
            sum_q  <= sum_nxt_o;
            max_q  <= max_nxt_o;
            min_q  <= min_nxt_o;
            if (last_o) open_q <= 1'b0;
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (cnt_q < n_i));

    // R6
    min_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (min_q <= max_q));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_q && !start_i) |=> $stable(sum_q));
endmodule

// File: rtl/tmf_reduce.sv
// Reducer: removes the extremes when trimming is on and divides by a power of two.
// Purely combinational; assumes sum >= max + min whenever trim_i is set.
module tmf_reduce
    import tmf_pkg::*;
#(
    parameter int RAW_W = 16,
    localparam int SUM_W = RAW_W + CNT_W
)(
    input  logic [SUM_W-1:0] sum_i,
    input  logic [RAW_W-1:0] max_i,
    input  logic [RAW_W-1:0] min_i,
    input  logic             trim_i,
    input  logic [SHF_W-1:0] shift_i,
    output logic [RAW_W-1:0] value_o
);
    logic [SUM_W-1:0] kept;
    logic [SUM_W-1:0] scaled;
    logic             unused_hi;

    // Subtract one max and one min, then shift by log2 of the kept count.
    always_comb begin
        kept   = trim_i ? (sum_i - SUM_W'(max_i) - SUM_W'(min_i)) : sum_i;
        scaled = kept >> shift_i;
    end

    assign value_o   = scaled[RAW_W-1:0];
    assign unused_hi = ^scaled[SUM_W-1:RAW_W];
endmodule

// File: rtl/trimmed_mean_filter.sv
// Trimmed-mean filter top: masks raw readings, runs one round per start strobe
// and registers one result per round. Assumes IN_W >= RAW_W.
module trimmed_mean_filter
    import tmf_pkg::*;
#(
    parameter int RAW_W = 16,
    parameter int IN_W  = 24,
    localparam int SUM_W = RAW_W + CNT_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       mode_i,
    input  logic             smp_valid_i,
    input  logic [IN_W-1:0]  smp_raw_i,
    output logic [CNT_W-1:0] req_count_o,
    output logic             res_valid_o,
    output logic [RAW_W-1:0] res_value_o
);
    tmf_cfg_t         cfg;
    logic [RAW_W-1:0] smp;
    logic             last;
    logic [SUM_W-1:0] sum_nxt;
    logic [RAW_W-1:0] max_nxt, min_nxt, value;
    logic             res_valid_q;
    logic [RAW_W-1:0] res_value_q;

    // Keep only the measurement field of the raw word.
    assign smp = smp_raw_i[RAW_W-1:0];
    generate
        if (IN_W > RAW_W) begin : g_drop
            logic unused_bits;
            assign unused_bits = ^smp_raw_i[IN_W-1:RAW_W];
        end
    endgenerate

    tmf_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .cfg_o(cfg)
    );

    tmf_accum #(.RAW_W(RAW_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_i(cfg.n),
        .smp_valid_i(smp_valid_i), .smp_i(smp), .last_o(last),
        .sum_nxt_o(sum_nxt), .max_nxt_o(max_nxt), .min_nxt_o(min_nxt)
    );

    tmf_reduce #(.RAW_W(RAW_W)) u_red (
        .sum_i(sum_nxt), .max_i(max_nxt), .min_i(min_nxt),
        .trim_i(cfg.trim), .shift_i(cfg.shift), .value_o(value)
    );

    // Capture the result on the closing reading and hold it until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_q <= 1'b0;
            res_value_q <= '0;
        end else begin
            res_valid_q <= last;
            if (last) res_value_q <= value;
        end
    end

    assign req_count_o = cfg.n;
    assign res_valid_o = res_valid_q;
    assign res_value_o = res_value_q;

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    // R11
    start_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !res_valid_o);

    // R9
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(res_value_o));
endmodule

// File: tb/tb_trimmed_mean_filter.sv
`timescale 1ns/1ps
module tb_trimmed_mean_filter;
    localparam int RAW_W = 16;
    localparam int IN_W  = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [2:0]       mode_i = '0;
    logic             smp_valid_i = 1'b0;
    logic [IN_W-1:0]  smp_raw_i = '0;
    logic [4:0]       req_count_o;
    logic             res_valid_o;
    logic [RAW_W-1:0] res_value_o;

    int nchk = 0;
    int nfail = 0;
    logic [IN_W-1:0] sbuf [18];

    trimmed_mean_filter #(.RAW_W(RAW_W), .IN_W(IN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .smp_valid_i(smp_valid_i), .smp_raw_i(smp_raw_i),
        .req_count_o(req_count_o), .res_valid_o(res_valid_o), .res_value_o(res_value_o)
    );

    always #2 clk = ~clk;

    // Vector: {mode[3], base[16], step[16], junk[8], n[5], expected[16]}.
    // Readings are base + step*((7*i) mod n) with junk in bits above RAW_W.
    localparam logic [63:0] VEC [10] = '{
        {3'd0, 16'd1234,  16'd0,   8'h00, 5'd1,  16'd1234},  // R4
        {3'd1, 16'd100,   16'd7,   8'h00, 5'd2,  16'd103},   // R5
        {3'd2, 16'd10,    16'd5,   8'h00, 5'd4,  16'd17},    // R6
        {3'd3, 16'd200,   16'd3,   8'h00, 5'd6,  16'd207},   // R6
        {3'd4, 16'd1000,  16'd11,  8'h00, 5'd10, 16'd1049},  // R6
        {3'd5, 16'd500,   16'd100, 8'h00, 5'd18, 16'd1350},  // R6
        {3'd6, 16'd42,    16'd0,   8'h00, 5'd1,  16'd42},    // R3
        {3'd7, 16'd65535, 16'd0,   8'h00, 5'd1,  16'd65535}, // R3
        {3'd5, 16'd65000, 16'd30,  8'h00, 5'd18, 16'd65255}, // R6
        {3'd2, 16'd300,   16'd2,   8'hAB, 5'd4,  16'd303}    // R8
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_start(input logic [2:0] m, input logic with_smp, input logic [IN_W-1:0] s);
        @(negedge clk);
        start_i = 1'b1; mode_i = m;
        smp_valid_i = with_smp; smp_raw_i = s;
        @(negedge clk);
        start_i = 1'b0; smp_valid_i = 1'b0;
    endtask

    // Feed n readings from sbuf back to back; result checks happen right after return.
    task automatic feed(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            smp_valid_i = 1'b1; smp_raw_i = sbuf[i];
            if (i != 0) chk({tag, " no early result"}, res_valid_o, 0);
            @(negedge clk);
        end
        smp_valid_i = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req in reset", req_count_o, 0);
        chk("R1 valid in reset", res_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req after reset", req_count_o, 0);
        chk("R1 value after reset", res_value_o, 0);

        // Vector walk over every mode.
        for (int v = 0; v < 10; v++) begin
            logic [63:0] e;
            int n;
            e = VEC[v];
            n = int'(e[20:16]);
            for (int i = 0; i < n; i++)
                sbuf[i] = {e[28:21], e[60:45] + e[44:29] * 16'((7 * i) % n)};
            do_start(e[63:61], 1'b0, '0);
            chk($sformatf("R2 req count vec %0d", v), req_count_o, e[20:16]);
            feed(n, "R9");
            chk($sformatf("R9 valid vec %0d", v), res_valid_o, 1);
            chk($sformatf("R6 value vec %0d", v), res_value_o, e[15:0]);
            @(negedge clk);
            chk($sformatf("R9 pulse end vec %0d", v), res_valid_o, 0);
            chk($sformatf("R9 value held vec %0d", v), res_value_o, e[15:0]);
        end

        // R7: ties on the minimum, one copy removed.
        sbuf[0] = 5; sbuf[1] = 5; sbuf[2] = 5; sbuf[3] = 9;
        do_start(3'd2, 1'b0, '0);
        feed(4, "R7");
        chk("R7 tied min", res_value_o, 5);
        // R7: ties on the maximum.
        sbuf[0] = 9; sbuf[1] = 9; sbuf[2] = 1; sbuf[3] = 9;
        do_start(3'd2, 1'b0, '0);
        feed(4, "R7");
        chk("R7 tied max", res_value_o, 9);
        // R6: extremes in the middle of the round.
        sbuf[0] = 50; sbuf[1] = 65535; sbuf[2] = 60; sbuf[3] = 0; sbuf[4] = 70; sbuf[5] = 80;
        do_start(3'd3, 1'b0, '0);
        feed(6, "R6");
        chk("R6 outliers", res_value_o, 65);

        // R10: readings while idle are ignored.
        for (int i = 0; i < 5; i++) begin
            smp_valid_i = 1'b1; smp_raw_i = 24'd9000 + 24'(i);
            @(negedge clk);
            chk("R10 no idle result", res_valid_o, 0);
        end
        smp_valid_i = 1'b0;
        chk("R10 value unchanged", res_value_o, 65);
        sbuf[0] = 77;
        do_start(3'd0, 1'b0, '0);
        feed(1, "R10");
        chk("R10 clean next round", res_value_o, 77);

        // R11: restart mid-round; the reading in the start cycle is dropped.
        sbuf[0] = 1000; sbuf[1] = 1000;
        do_start(3'd2, 1'b0, '0);
        feed(2, "R11");
        do_start(3'd1, 1'b1, 24'd9999);
        chk("R11 no result at restart", res_valid_o, 0);
        chk("R11 req count", req_count_o, 2);
        sbuf[0] = 4; sbuf[1] = 6;
        feed(2, "R11");
        chk("R11 valid", res_valid_o, 1);
        chk("R11 value", res_value_o, 5);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule